// File: doc/BRIEF.md
# EEPROM Software Write-Protect Sequencer

This block sits on the write path between an 8-bit microcontroller bus and a byte-wide EEPROM array. It watches the address/data pair of every bus write. Short unlock sequences written to two fixed command addresses turn a software protect flag on or off. When the flag is set, the block forwards a data write to the array only if the three-write unlock prefix comes just before it. When the flag is clear, ordinary writes pass straight through.

A gap timer, counted in microsecond ticks, abandons any half-entered sequence. Ready/busy is a single output. It is low from the opening key write until the internal store finishes. The store takes a programmable number of ticks. While a store runs, a status read returns a bit 6 that toggles on every read. At other times a status read returns the array data unchanged. The protect flag has no power-on reset. A separate restore input loads it at power-up, so its value survives a power cycle.

The sequencer is an eight-state machine:

- `SQ_IDLE`: rest state.
- `SQ_K1` and `SQ_K2`: the two key writes have been seen.
- `SQ_ARM`: the lock opcode has been seen and the data write is awaited.
- `SQ_U3`, `SQ_U4` and `SQ_U5`: the steps of the unlock tail.
- `SQ_STORE`: the write-cycle timer is running.

Transitions:

| From | Condition | To |
|------|-----------|----|
| `SQ_IDLE` | key one | `SQ_K1` |
| `SQ_K1` | key two | `SQ_K2` |
| `SQ_K2` | lock opcode | `SQ_ARM` |
| `SQ_K2` | pre-opcode | `SQ_U3` |
| `SQ_U3` | key one | `SQ_U4` |
| `SQ_U4` | key two | `SQ_U5` |
| `SQ_U5` | open opcode | `SQ_STORE` (clear kind) |
| `SQ_ARM` | any write | `SQ_STORE` (set kind) |
| `SQ_ARM` | gap expiry | `SQ_STORE` (set kind) |
| any sequence state | mismatching write | `SQ_IDLE` |
| any sequence state | gap expiry, except in `SQ_ARM` | `SQ_IDLE` |
| `SQ_STORE` | timer expiry | `SQ_IDLE` (commit) |

Top module: `eewp_seq`

## Requirements
- R1: After reset `rdy` is 1, `arr_we` is 0 and `stat_q` is 00h.
- R2: With the protect flag clear, a write outside any sequence appears on `arr_we`/`arr_addr`/`arr_wdata` in the cycle after it is sampled.
- R3: The lock sequence is AAh@555h, 55h@AAAh, A0h@555h. None of its writes reach the array. With the flag clear, the write that follows it is forwarded. The flag becomes 1 when the store ends, TWC_US ticks later.
- R4: With the flag set, a write with no unlock prefix is not forwarded and leaves the flag unchanged.
- R5: With the flag set, the lock prefix followed by one data write forwards that write, and the flag stays set after the store.
- R6: The unlock sequence AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, 20h@555h forwards nothing and clears the flag when the store ends.
- R7: A gap of more than TMO_US ticks between two sequence writes abandons the sequence. A write that arrives in the same cycle as the expiring tick still counts as the next step.
- R8: If the gap expires in `SQ_ARM`, the store starts anyway and the lock is committed.
- R9: A write that does not match the expected step returns the machine to idle. That write is then judged as an ordinary write under the current flag.
- R10: `rdy` falls in the cycle after AAh@555h is sampled and rises when the store ends. Writes made during the store are ignored.
- R11: During a store, bit 6 of `stat_q` reads 1, 0, 1, … on successive reads. The other bits follow `arr_rdata`.
- R12: When no store is running, a status read returns `arr_rdata` unchanged.
- R13: `prot_flag` loads `nv_val` when `nv_ld` is high and is not changed by `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, does not touch the flag |
| us_tick | input | 1 | One-cycle microsecond pulse |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Status read strobe |
| addr | input | 12 | Bus address |
| wdata | input | 8 | Bus write data |
| arr_rdata | input | 8 | Array data at the read address |
| nv_ld | input | 1 | Restore strobe for the protect flag |
| nv_val | input | 1 | Restored protect value |
| arr_we | output | 1 | Array write request |
| arr_addr | output | 12 | Array write address |
| arr_wdata | output | 8 | Array write data |
| prot_flag | output | 1 | Software protect flag |
| rdy | output | 1 | Ready (1) / busy (0) |
| stat_q | output | 8 | Status read data |

## Verification
Gap expiry and a new sequence write can land in the same clock cycle. The write must win. The bench provokes this by waiting exactly TMO_US ticks after a key write and then driving the next step together with a tick pulse. It judges the outcome by whether the following data write is forwarded and whether the flag is set once the store ends. In a second race, a status read arrives while the store timer runs. The toggling bit 6 is compared with the expected 1, 0, 1 series.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
    localparam int unsigned EE_AW = 12;
    localparam int unsigned EE_DW = 8;

    localparam logic [EE_AW-1:0] CMD_ADR_LO = 12'h555;
    localparam logic [EE_AW-1:0] CMD_ADR_HI = 12'hAAA;
    localparam logic [EE_DW-1:0] KEY_ONE    = 8'hAA;
    localparam logic [EE_DW-1:0] KEY_TWO    = 8'h55;
    localparam logic [EE_DW-1:0] OP_LOCK    = 8'hA0;
    localparam logic [EE_DW-1:0] OP_PRE     = 8'h80;
    localparam logic [EE_DW-1:0] OP_OPEN    = 8'h20;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_ARM,
        SQ_U3,
        SQ_U4,
        SQ_U5,
        SQ_STORE
    } sq_state_t;

    typedef enum logic {
        ST_LOCK,
        ST_OPEN
    } st_kind_t;

    typedef struct packed {
        logic key1;
        logic key2;
        logic lock;
        logic pre;
        logic open;
    } step_hit_t;
endpackage

// File: rtl/eewp_step_dec.sv
module eewp_step_dec
    import eewp_pkg::*;
(
    input  logic [EE_AW-1:0] addr,
    input  logic [EE_DW-1:0] wdata,
    output step_hit_t        hit
);
    logic at_lo;
    logic at_hi;

    assign at_lo = (addr == CMD_ADR_LO);
    assign at_hi = (addr == CMD_ADR_HI);

    always_comb begin
        hit.key1 = at_lo && (wdata == KEY_ONE);
        hit.key2 = at_hi && (wdata == KEY_TWO);
        hit.lock = at_lo && (wdata == OP_LOCK);
        hit.pre  = at_lo && (wdata == OP_PRE);
        hit.open = at_lo && (wdata == OP_OPEN);
    end
endmodule

// File: rtl/eewp_ucnt.sv
module eewp_ucnt #(
    parameter int unsigned LIMIT = 121
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt != LIM_M1)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expire = tick && !clr && (cnt == LIM_M1);
endmodule

// File: rtl/eewp_fsm.sv
module eewp_fsm
    import eewp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  step_hit_t hit,
    input  logic      prot,
    input  logic      gap_exp,
    input  logic      wc_exp,
    output sq_state_t st,
    output logic      pass,
    output logic      go_store,
    output logic      commit_lock,
    output logic      commit_open
);
    sq_state_t nxt;
    st_kind_t  kind;
    st_kind_t  nxt_kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= SQ_IDLE;
            kind <= ST_LOCK;
        end else begin
            st <= nxt;
            if (go_store) begin
                kind <= nxt_kind;
            end
        end
    end

    always_comb begin
        nxt         = st;
        nxt_kind    = kind;
        pass        = 1'b0;
        go_store    = 1'b0;
        commit_lock = 1'b0;
        commit_open = 1'b0;
        unique case (st)
            SQ_IDLE: begin
                if (wr_en) begin
                    if (hit.key1) nxt = SQ_K1;
                    else          pass = !prot;
                end
            end
            SQ_K1, SQ_U4: begin
                if (wr_en) begin
                    if (hit.key2) begin
                        nxt = (st == SQ_K1) ? SQ_K2 : SQ_U5;
                    end else begin
                        nxt  = SQ_IDLE;
                        pass = !prot;
                    end
                end else if (gap_exp) begin
                    nxt = SQ_IDLE;
                end
            end
            SQ_K2: begin
                if (wr_en) begin
                    if (hit.lock) begin
                        nxt = SQ_ARM;
                    end else if (hit.pre) begin
                        nxt = SQ_U3;
                    end else begin
                        nxt  = SQ_IDLE;
                        pass = !prot;
                    end
                end else if (gap_exp) begin
                    nxt = SQ_IDLE;
                end
            end
            SQ_ARM: begin
                if (wr_en || gap_exp) begin
                    pass     = wr_en;
                    nxt      = SQ_STORE;
                    nxt_kind = ST_LOCK;
                    go_store = 1'b1;
                end
            end
            SQ_U3: begin
                if (wr_en) begin
                    if (hit.key1) begin
                        nxt = SQ_U4;
                    end else begin
                        nxt  = SQ_IDLE;
                        pass = !prot;
                    end
                end else if (gap_exp) begin
                    nxt = SQ_IDLE;
                end
            end
            SQ_U5: begin
                if (wr_en) begin
                    if (hit.open) begin
                        nxt      = SQ_STORE;
                        nxt_kind = ST_OPEN;
                        go_store = 1'b1;
                    end else begin
                        nxt  = SQ_IDLE;
                        pass = !prot;
                    end
                end else if (gap_exp) begin
                    nxt = SQ_IDLE;
                end
            end
            SQ_STORE: begin
                if (wc_exp) begin
                    nxt         = SQ_IDLE;
                    commit_lock = (kind == ST_LOCK);
                    commit_open = (kind == ST_OPEN);
                end
            end
        endcase
    end
endmodule

// File: rtl/eewp_stat.sv
module eewp_stat
    import eewp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             busy_store,
    input  logic             store_start,
    input  logic [EE_DW-1:0] arr_rdata,
    output logic [EE_DW-1:0] stat_q
);
    logic tgl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl    <= 1'b0;
            stat_q <= '0;
        end else begin
            if (store_start) begin
                tgl <= 1'b0;
            end else if (rd_en && busy_store) begin
                tgl <= ~tgl;
            end
            if (rd_en) begin
                if (busy_store) begin
                    stat_q <= {arr_rdata[EE_DW-1], ~tgl, arr_rdata[EE_DW-3:0]};
                end else begin
                    stat_q <= arr_rdata;
                end
            end
        end
    end
endmodule

// File: rtl/eewp_seq.sv
module eewp_seq
    import eewp_pkg::*;
#(
    parameter int unsigned TMO_US = 120,
    parameter int unsigned TWC_US = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [EE_AW-1:0] addr,
    input  logic [EE_DW-1:0] wdata,
    input  logic [EE_DW-1:0] arr_rdata,
    input  logic             nv_ld,
    input  logic             nv_val,
    output logic             arr_we,
    output logic [EE_AW-1:0] arr_addr,
    output logic [EE_DW-1:0] arr_wdata,
    output logic             prot_flag,
    output logic             rdy,
    output logic [EE_DW-1:0] stat_q
);
    localparam int unsigned GAP_LIM = TMO_US + 1;

    step_hit_t hit;
    sq_state_t st;
    logic      pass;
    logic      go_store;
    logic      commit_lock;
    logic      commit_open;
    logic      gap_exp;
    logic      wc_exp;
    logic      gap_clr;
    logic      in_store;

    assign in_store = (st == SQ_STORE);
    assign gap_clr  = wr_en || (st == SQ_IDLE) || in_store;
    assign rdy      = (st == SQ_IDLE);

    eewp_step_dec u_dec (
        .addr  (addr),
        .wdata (wdata),
        .hit   (hit)
    );

    eewp_ucnt #(.LIMIT(GAP_LIM)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (gap_clr),
        .tick   (us_tick),
        .expire (gap_exp)
    );

    eewp_ucnt #(.LIMIT(TWC_US)) u_wc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!in_store),
        .tick   (us_tick),
        .expire (wc_exp)
    );

    eewp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .hit         (hit),
        .prot        (prot_flag),
        .gap_exp     (gap_exp),
        .wc_exp      (wc_exp),
        .st          (st),
        .pass        (pass),
        .go_store    (go_store),
        .commit_lock (commit_lock),
        .commit_open (commit_open)
    );

    eewp_stat u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .busy_store  (in_store),
        .store_start (go_store),
        .arr_rdata   (arr_rdata),
        .stat_q      (stat_q)
    );

    // Protect flag: no reset, restored through nv_ld.
    always_ff @(posedge clk) begin
        if (nv_ld) begin
            prot_flag <= nv_val;
        end else if (commit_lock) begin
            prot_flag <= 1'b1;
        end else if (commit_open) begin
            prot_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_we    <= 1'b0;
            arr_addr  <= '0;
            arr_wdata <= '0;
        end else begin
            arr_we <= pass;
            if (pass) begin
                arr_addr  <= addr;
                arr_wdata <= wdata;
            end
        end
    end
endmodule

// File: rtl/eewp_seq_chk.sv
module eewp_seq_chk
    import eewp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [EE_AW-1:0] addr,
    input logic [EE_DW-1:0] wdata,
    input logic [EE_DW-1:0] arr_rdata,
    input logic             nv_ld,
    input logic             arr_we,
    input logic             prot_flag,
    input logic             rdy,
    input logic [EE_DW-1:0] stat_q,
    input sq_state_t        st
);
    assert_we_follows_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $past(wr_en));

    assert_lock_from_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_flag) |-> ($past(nv_ld) || $past(st) == SQ_STORE));

    assert_flag_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nv_ld && st != SQ_STORE) |=> $stable(prot_flag));

    assert_open_from_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_flag) |-> ($past(nv_ld) || $past(st) == SQ_STORE));

    assert_busy_on_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(wr_en && addr == CMD_ADR_LO && wdata == KEY_ONE));

    assert_no_write_in_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_STORE && wr_en) |=> !arr_we);

    assert_plain_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st != SQ_STORE) |=> (stat_q == $past(arr_rdata)));
endmodule

bind eewp_seq eewp_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .arr_rdata (arr_rdata),
    .nv_ld     (nv_ld),
    .arr_we    (arr_we),
    .prot_flag (prot_flag),
    .rdy       (rdy),
    .stat_q    (stat_q),
    .st        (st)
);

// File: tb/eewp_seq_bench.sv
module eewp_seq_bench;
    localparam int TMO = 120;
    localparam int TWC = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  arr_rdata = 8'h3C;
    logic        nv_ld = 1'b0;
    logic        nv_val = 1'b0;
    logic        arr_we;
    logic [11:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic        prot_flag;
    logic        rdy;
    logic [7:0]  stat_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic mprot;

    always #2 clk = ~clk;

    eewp_seq #(.TMO_US(TMO), .TWC_US(TWC)) u_eewp_seq (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .arr_rdata(arr_rdata), .nv_ld(nv_ld), .nv_val(nv_val),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .prot_flag(prot_flag), .rdy(rdy), .stat_q(stat_q)
    );

    function automatic logic exp_fwd(input logic p, input logic [11:0] a, input logic [7:0] d);
        return !p && !(a == 12'h555 && d == 8'hAA);
    endfunction

    function automatic logic [7:0] exp_busy_stat(input logic [7:0] r, input int n);
        return {r[7], (n % 2 == 1), r[5:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic ld, input logic v);
        @(negedge clk);
        rst_n = 1'b0; nv_ld = ld; nv_val = v;
        @(negedge clk);
        @(negedge clk);
        nv_ld = 1'b0; rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic tk,
                      input logic exp_we, input string tag);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; us_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; us_tick = 1'b0;
        chk(tag, arr_we, exp_we);
        if (exp_we) begin
            chk(tag, arr_addr, a);
            chk(tag, arr_wdata, d);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) us_tick = 1'b1;
            @(negedge clk) us_tick = 1'b0;
        end
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        v = stat_q;
    endtask

    task automatic lock_prefix(input string tag);
        wr(12'h555, 8'hAA, 1'b0, 1'b0, tag);
        chk({tag, " rdy"}, rdy, 1'b0);
        wr(12'hAAA, 8'h55, 1'b0, 1'b0, tag);
        wr(12'h555, 8'hA0, 1'b0, 1'b0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] s;
        void'($urandom(32'd5577));
        do_reset(1'b1, 1'b0);
        mprot = 1'b0;
        // R1 reset state
        chk("R1 rdy", rdy, 1'b1);
        chk("R1 arr_we", arr_we, 1'b0);
        chk("R1 stat_q", stat_q, 8'h00);
        chk("R13 restore 0", prot_flag, 1'b0);

        // R2 random ordinary writes, flag clear
        for (int i = 0; i < 20; i++) begin
            logic [11:0] a = 12'($urandom);
            logic [7:0]  d = 8'($urandom);
            if (a == 12'h555 && d == 8'hAA) d = 8'hAB;
            wr(a, d, 1'b0, exp_fwd(mprot, a, d), "R2 plain write");
        end

        // R3 lock with flag clear, data forwarded, store, flag set
        lock_prefix("R3 step");
        wr(12'h100, 8'h12, 1'b0, 1'b1, "R3 data");
        wr(12'h101, 8'h34, 1'b0, 1'b0, "R10 write in store");
        arr_rdata = 8'h3C;
        for (int n = 1; n <= 3; n++) begin
            rd(s);
            chk("R11 toggle", s, exp_busy_stat(arr_rdata, n));
        end
        ticks(TWC - 1);
        chk("R10 still busy", rdy, 1'b0);
        chk("R3 not yet", prot_flag, 1'b0);
        ticks(1);
        mprot = 1'b1;
        chk("R10 ready", rdy, 1'b1);
        chk("R3 flag set", prot_flag, mprot);

        // R4 random writes with flag set
        for (int i = 0; i < 20; i++) begin
            logic [11:0] a = 12'($urandom);
            logic [7:0]  d = 8'($urandom);
            if (a == 12'h555 && d == 8'hAA) d = 8'hAB;
            wr(a, d, 1'b0, exp_fwd(mprot, a, d), "R4 no prefix");
        end
        chk("R4 flag", prot_flag, 1'b1);

        // R5 prefix + data with flag set
        lock_prefix("R5 step");
        wr(12'h2F0, 8'h99, 1'b0, 1'b1, "R5 data");
        ticks(TWC);
        chk("R5 flag kept", prot_flag, 1'b1);
        chk("R5 ready", rdy, 1'b1);

        // R12 idle status reads
        arr_rdata = 8'hC5;
        rd(s); chk("R12 read 1", s, 8'hC5);
        rd(s); chk("R12 read 2", s, 8'hC5);

        // R9 mismatch with flag set
        wr(12'h555, 8'hAA, 1'b0, 1'b0, "R9 key");
        wr(12'h200, 8'h11, 1'b0, 1'b0, "R9 mismatch locked");
        chk("R9 idle", rdy, 1'b1);

        // R6 unlock sequence
        wr(12'h555, 8'hAA, 1'b0, 1'b0, "R6 s1");
        wr(12'hAAA, 8'h55, 1'b0, 1'b0, "R6 s2");
        wr(12'h555, 8'h80, 1'b0, 1'b0, "R6 s3");
        wr(12'h555, 8'hAA, 1'b0, 1'b0, "R6 s4");
        wr(12'hAAA, 8'h55, 1'b0, 1'b0, "R6 s5");
        wr(12'h555, 8'h20, 1'b0, 1'b0, "R6 s6");
        chk("R6 busy", rdy, 1'b0);
        ticks(TWC);
        mprot = 1'b0;
        chk("R6 flag clear", prot_flag, mprot);

        // R9 mismatch with flag clear: forwarded
        wr(12'h555, 8'hAA, 1'b0, 1'b0, "R9 key2");
        wr(12'h123, 8'h77, 1'b0, 1'b1, "R9 mismatch open");
        chk("R9 idle2", rdy, 1'b1);

        // R7 timeout abandons
        wr(12'h555, 8'hAA, 1'b0, 1'b0, "R7 key");
        ticks(TMO + 1);
        chk("R7 abandoned", rdy, 1'b1);
        wr(12'hAAA, 8'h55, 1'b0, 1'b1, "R7 late step plain");

        // R7 write in same cycle as expiring tick wins
        wr(12'h555, 8'hAA, 1'b0, 1'b0, "R7 race key");
        ticks(TMO);
        wr(12'hAAA, 8'h55, 1'b1, 1'b0, "R7 race step");
        chk("R7 race busy", rdy, 1'b0);
        wr(12'h555, 8'hA0, 1'b0, 1'b0, "R7 race lock");
        wr(12'h300, 8'h5A, 1'b0, 1'b1, "R7 race data");
        ticks(TWC);
        mprot = 1'b1;
        chk("R7 race flag", prot_flag, mprot);

        // R8 gap expiry in armed state starts store
        lock_prefix("R8 step");
        ticks(TMO + 1);
        chk("R8 storing", rdy, 1'b0);
        wr(12'h310, 8'h66, 1'b0, 1'b0, "R8 write in store");
        ticks(TWC);
        chk("R8 ready", rdy, 1'b1);
        chk("R8 flag", prot_flag, 1'b1);

        // R13 flag survives reset, restore loads it
        do_reset(1'b0, 1'b0);
        chk("R13 kept over reset", prot_flag, 1'b1);
        chk("R1 rdy after reset", rdy, 1'b1);
        do_reset(1'b1, 1'b0);
        chk("R13 restore", prot_flag, 1'b0);

        finish_run();
    end
endmodule